// File: doc/BRIEF.md
# DMA Channel Frame-End and Buffer-Error Status

This block holds the per-channel status flags and interrupt requests of a DMA controller that walks a chain of descriptors. One side tracks completed frames. A single end-of-frame flag can be backed by a 4-bit pending-frame counter. When the counter is enabled, software acknowledges frames one at a time, and the flag stays up until every counted frame has been acknowledged. The other side watches for the descriptor ring running dry. A peripheral transfer request that arrives while the current descriptor pointer equals the error descriptor pointer raises a buffer-error flag. In the receive direction this is an overflow; in the transmit direction it is an underflow. Both directions share the same detection.

Software writes one to a flag strobe to acknowledge it. A command input empties the counter. Each flag, gated by its own enable, drives its own registered interrupt request. The flags operate only in chained mode. In single-block mode they are reserved and keep whatever value they held.

Top module: `dma_frame_status`

## Requirements
- R1: While `rst_n` is low, `eof_flag`, `bof_flag`, `frame_cnt`, `eof_irq` and `bof_irq` are all zero.
- R2: In chained mode with `cnt_en` low, `frame_done` sets `eof_flag` and `eof_w1c` clears it. When both arrive in the same cycle the flag ends up set. `frame_cnt` holds.
- R3: In chained mode with `cnt_en` high, `frame_done` (without a decrementing write) sets `eof_flag` and adds one to `frame_cnt`.
- R4: In chained mode with `cnt_en` high and `frame_cnt` nonzero, `eof_w1c` alone subtracts one from `frame_cnt`. `eof_flag` clears only when the result is zero and otherwise stays set.
- R5: In chained mode with `cnt_en` high and `frame_cnt` zero, `eof_w1c` alone changes neither `frame_cnt` nor `eof_flag`.
- R6: In chained mode with `cnt_en` high and `frame_cnt` nonzero, `frame_done` together with `eof_w1c` leaves `frame_cnt` unchanged and `eof_flag` set.
- R7: In chained mode with `cnt_en` high, `frame_done` without `eof_w1c` while `frame_cnt` is 4'b1111 sets `frame_cnt` to 0 and sets `eof_flag`.
- R8: `cnt_clr` clears `eof_flag` and `frame_cnt` in the next cycle in any mode. It overrides every other event.
- R9: In chained mode, `xfer_req` while `cur_desc == err_desc` sets `bof_flag`, and `bof_w1c` clears it. When both arrive in the same cycle the flag ends up set.
- R10: With `chain_mode` low and no `cnt_clr`, `frame_done`, `xfer_req`, `eof_w1c` and `bof_w1c` have no effect: both flags and `frame_cnt` hold.
- R11: `eof_irq` equals `eof_flag & eof_ie` from the previous cycle, and `bof_irq` equals `bof_flag & bof_ie` from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_mode | input | 1 | 1 = chained-descriptor mode, 0 = single-block mode |
| cnt_en | input | 1 | Enables the pending-frame counter |
| frame_done | input | 1 | Pulse: a frame finished normally |
| xfer_req | input | 1 | Peripheral transfer request |
| cur_desc | input | AW | Current descriptor address |
| err_desc | input | AW | Error descriptor address |
| eof_w1c | input | 1 | Software write of one to the end-of-frame flag |
| bof_w1c | input | 1 | Software write of one to the buffer-error flag |
| cnt_clr | input | 1 | Counter-clear command |
| eof_ie | input | 1 | End-of-frame interrupt enable |
| bof_ie | input | 1 | Buffer-error interrupt enable |
| eof_flag | output | 1 | End-of-frame status flag |
| bof_flag | output | 1 | Buffer overflow/underflow flag |
| frame_cnt | output | CNT_W | Pending-frame counter |
| eof_irq | output | 1 | End-of-frame interrupt request |
| bof_irq | output | 1 | Buffer-error interrupt request |

## Verification
The bench drives the counter through all sixteen values so that it wraps from 1111 to zero. A design that wrapped without forcing the flag on would drop an interrupt there. It also acknowledges at a count of zero: a counter that underflowed would show 1111. It fires completion and acknowledge in the same cycle, where a design that applied both separately would lose or invent a frame. It toggles single-block mode while strobes are active, so a design that let reserved writes through would change a flag. Random traffic with narrow descriptor addresses makes address matches frequent, and a per-cycle reference model tags each mismatch with the rule that applied.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  // Counter update chosen by the next-state logic.
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2,
    CNT_ZERO = 2'd3
  } cnt_op_e;

  localparam int unsigned IRQ_LINES = 2;
  localparam int unsigned IRQ_EOF   = 0;
  localparam int unsigned IRQ_BOF   = 1;
endpackage

// File: rtl/dfs_eof_tracker.sv
module dfs_eof_tracker
  import dfs_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chain_mode,
  input  logic             cnt_en,
  input  logic             frame_done,
  input  logic             eof_w1c,
  input  logic             cnt_clr,
  output logic             eof_flag,
  output logic [CNT_W-1:0] frame_cnt
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             flag_q, flag_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  cnt_op_e          op;
  logic             upd_en;
  logic             cnt_zero, cnt_full;

  assign cnt_zero = (cnt_q == '0);
  assign cnt_full = (cnt_q == '1);
  assign upd_en   = cnt_clr | chain_mode;

  always_comb begin
    op     = CNT_HOLD;
    flag_d = flag_q;
    if (cnt_clr) begin
      op     = CNT_ZERO;
      flag_d = 1'b0;
    end else if (chain_mode) begin
      if (!cnt_en) begin
        if (frame_done)   flag_d = 1'b1;
        else if (eof_w1c) flag_d = 1'b0;
      end else if (frame_done && eof_w1c && !cnt_zero) begin
        flag_d = 1'b1;
      end else if (frame_done) begin
        flag_d = 1'b1;
        op     = cnt_full ? CNT_ZERO : CNT_INC;
      end else if (eof_w1c && !cnt_zero) begin
        op = CNT_DEC;
        if (cnt_q == CNT_ONE) flag_d = 1'b0;
      end
    end
  end

  always_comb begin
    unique case (op)
      CNT_INC:  cnt_d = cnt_q + CNT_ONE;
      CNT_DEC:  cnt_d = cnt_q - CNT_ONE;
      CNT_ZERO: cnt_d = '0;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
    end
  end

  assign eof_flag  = flag_q;
  assign frame_cnt = cnt_q;
endmodule

// File: rtl/dfs_buf_err.sv
module dfs_buf_err #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chain_mode,
  input  logic          xfer_req,
  input  logic [AW-1:0] cur_desc,
  input  logic [AW-1:0] err_desc,
  input  logic          bof_w1c,
  output logic          bof_flag
);
  logic flag_q, flag_d;
  logic ring_empty;

  assign ring_empty = (cur_desc == err_desc);

  always_comb begin
    flag_d = flag_q;
    if (xfer_req && ring_empty) flag_d = 1'b1;
    else if (bof_w1c)           flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (chain_mode) flag_q <= flag_d;
  end

  assign bof_flag = flag_q;
endmodule

// File: rtl/dfs_irq_stage.sv
module dfs_irq_stage #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag,
  input  logic [N-1:0] en,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic req_d, req_q;
    assign req_d = flag[i] & en[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= req_d;
    end
    assign irq[i] = req_q;
  end
endmodule

// File: rtl/dma_frame_status.sv
module dma_frame_status
  import dfs_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned AW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chain_mode,
  input  logic             cnt_en,
  input  logic             frame_done,
  input  logic             xfer_req,
  input  logic [AW-1:0]    cur_desc,
  input  logic [AW-1:0]    err_desc,
  input  logic             eof_w1c,
  input  logic             bof_w1c,
  input  logic             cnt_clr,
  input  logic             eof_ie,
  input  logic             bof_ie,
  output logic             eof_flag,
  output logic             bof_flag,
  output logic [CNT_W-1:0] frame_cnt,
  output logic             eof_irq,
  output logic             bof_irq
);
  logic [IRQ_LINES-1:0] flags, enables, irqs;

  dfs_eof_tracker #(.CNT_W(CNT_W)) u_eof (
    .clk        (clk),
    .rst_n      (rst_n),
    .chain_mode (chain_mode),
    .cnt_en     (cnt_en),
    .frame_done (frame_done),
    .eof_w1c    (eof_w1c),
    .cnt_clr    (cnt_clr),
    .eof_flag   (eof_flag),
    .frame_cnt  (frame_cnt)
  );

  dfs_buf_err #(.AW(AW)) u_bof (
    .clk        (clk),
    .rst_n      (rst_n),
    .chain_mode (chain_mode),
    .xfer_req   (xfer_req),
    .cur_desc   (cur_desc),
    .err_desc   (err_desc),
    .bof_w1c    (bof_w1c),
    .bof_flag   (bof_flag)
  );

  assign flags[IRQ_EOF]   = eof_flag;
  assign flags[IRQ_BOF]   = bof_flag;
  assign enables[IRQ_EOF] = eof_ie;
  assign enables[IRQ_BOF] = bof_ie;

  dfs_irq_stage #(.N(IRQ_LINES)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .flag  (flags),
    .en    (enables),
    .irq   (irqs)
  );

  assign eof_irq = irqs[IRQ_EOF];
  assign bof_irq = irqs[IRQ_BOF];
endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned AW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chain_mode,
  input logic             cnt_en,
  input logic             frame_done,
  input logic             xfer_req,
  input logic [AW-1:0]    cur_desc,
  input logic [AW-1:0]    err_desc,
  input logic             eof_w1c,
  input logic             bof_w1c,
  input logic             cnt_clr,
  input logic             eof_ie,
  input logic             bof_ie,
  input logic             eof_flag,
  input logic             bof_flag,
  input logic [CNT_W-1:0] frame_cnt,
  input logic             eof_irq,
  input logic             bof_irq
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> (!eof_flag && !bof_flag && frame_cnt == '0 && !eof_irq && !bof_irq));

  // R3
  frame_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_mode && !cnt_clr && frame_done) |=> eof_flag);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_mode && cnt_en && !cnt_clr && eof_w1c && !frame_done && frame_cnt == '0)
    |=> (frame_cnt == '0 && $stable(eof_flag)));

  // R7
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_mode && cnt_en && !cnt_clr && frame_done && !eof_w1c && frame_cnt == '1)
    |=> (frame_cnt == '0 && eof_flag));

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (!eof_flag && frame_cnt == '0));

  // R9
  ring_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_mode && xfer_req && cur_desc == err_desc) |=> bof_flag);

  // R10
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_mode && !cnt_clr)
    |=> ($stable(eof_flag) && $stable(bof_flag) && $stable(frame_cnt)));

  // R11
  eof_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_irq == $past(eof_flag && eof_ie));

  // R11
  bof_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bof_irq == $past(bof_flag && bof_ie));
endmodule

bind dma_frame_status dfs_checker #(.CNT_W(CNT_W), .AW(AW)) u_dfs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chain_mode (chain_mode),
  .cnt_en     (cnt_en),
  .frame_done (frame_done),
  .xfer_req   (xfer_req),
  .cur_desc   (cur_desc),
  .err_desc   (err_desc),
  .eof_w1c    (eof_w1c),
  .bof_w1c    (bof_w1c),
  .cnt_clr    (cnt_clr),
  .eof_ie     (eof_ie),
  .bof_ie     (bof_ie),
  .eof_flag   (eof_flag),
  .bof_flag   (bof_flag),
  .frame_cnt  (frame_cnt),
  .eof_irq    (eof_irq),
  .bof_irq    (bof_irq)
);

// File: tb/test_dma_frame_status.sv
module test_dma_frame_status;
  localparam int CW = 4;
  localparam int AW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chain_mode = 1'b0, cnt_en = 1'b0, frame_done = 1'b0, xfer_req = 1'b0;
  logic [AW-1:0] cur_desc = '0, err_desc = 3'd1;
  logic eof_w1c = 1'b0, bof_w1c = 1'b0, cnt_clr = 1'b0, eof_ie = 1'b0, bof_ie = 1'b0;
  logic eof_flag, bof_flag, eof_irq, bof_irq;
  logic [CW-1:0] frame_cnt;

  always #2.5 clk = ~clk;

  dma_frame_status #(.CNT_W(CW), .AW(AW)) i_dma_frame_status (
    .clk(clk), .rst_n(rst_n), .chain_mode(chain_mode), .cnt_en(cnt_en),
    .frame_done(frame_done), .xfer_req(xfer_req), .cur_desc(cur_desc),
    .err_desc(err_desc), .eof_w1c(eof_w1c), .bof_w1c(bof_w1c), .cnt_clr(cnt_clr),
    .eof_ie(eof_ie), .bof_ie(bof_ie), .eof_flag(eof_flag), .bof_flag(bof_flag),
    .frame_cnt(frame_cnt), .eof_irq(eof_irq), .bof_irq(bof_irq)
  );

  // Behavioural reference state
  int m_cnt = 0;
  bit m_eof = 0, m_bof = 0, m_eirq = 0, m_birq = 0;
  string eof_tag = "R1", bof_tag = "R1";
  bit started = 0, finished = 0;
  int n_cmp = 0, n_bad = 0, cyc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_eof = 0; m_bof = 0; m_eirq = 0; m_birq = 0;
      eof_tag = "R1"; bof_tag = "R1";
    end else begin
      m_eirq = m_eof && eof_ie;
      m_birq = m_bof && bof_ie;
      if (cnt_clr) begin
        m_eof = 0; m_cnt = 0; eof_tag = "R8";
      end else if (!chain_mode) begin
        eof_tag = "R10";
      end else if (!cnt_en) begin
        eof_tag = "R2";
        if (frame_done) m_eof = 1;
        else if (eof_w1c) m_eof = 0;
      end else if (frame_done && eof_w1c && m_cnt > 0) begin
        eof_tag = "R6"; m_eof = 1;
      end else if (frame_done) begin
        m_eof = 1;
        if (m_cnt == CMAX) begin m_cnt = 0; eof_tag = "R7"; end
        else begin m_cnt++; eof_tag = "R3"; end
      end else if (eof_w1c) begin
        if (m_cnt == 0) eof_tag = "R5";
        else begin
          eof_tag = "R4"; m_cnt--;
          if (m_cnt == 0) m_eof = 0;
        end
      end
      if (!chain_mode) bof_tag = "R10";
      else begin
        bof_tag = "R9";
        if (xfer_req && cur_desc == err_desc) m_bof = 1;
        else if (bof_w1c) m_bof = 0;
      end
    end
    started = 1;
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      cmp(eof_tag, "eof_flag", int'(eof_flag), int'(m_eof));
      cmp(eof_tag, "frame_cnt", int'(frame_cnt), m_cnt);
      cmp(bof_tag, "bof_flag", int'(bof_flag), int'(m_bof));
      cmp(rst_n ? "R11" : "R1", "eof_irq", int'(eof_irq), int'(m_eirq));
      cmp(rst_n ? "R11" : "R1", "bof_irq", int'(bof_irq), int'(m_birq));
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic idle(input int n);
    frame_done = 0; eof_w1c = 0; bof_w1c = 0; xfer_req = 0; cnt_clr = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit fd, input bit ew, input bit xr, input bit bw, input bit cc);
    frame_done = fd; eof_w1c = ew; xfer_req = xr; bof_w1c = bw; cnt_clr = cc;
    @(negedge clk);
    idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);              // R1 checked while held
    rst_n = 1;
    eof_ie = 1; bof_ie = 1; chain_mode = 1; cnt_en = 0;
    // R2: plain set/clear and simultaneous
    pulse(1, 0, 0, 0, 0); pulse(0, 1, 0, 0, 0); pulse(1, 1, 0, 0, 0); pulse(0, 1, 0, 0, 0);
    // R9: match, w1c, both, non-match
    cur_desc = 3'd2; err_desc = 3'd2;
    pulse(0, 0, 1, 0, 0); pulse(0, 0, 0, 1, 0); pulse(0, 0, 1, 1, 0);
    err_desc = 3'd5; pulse(0, 0, 1, 0, 0); pulse(0, 0, 0, 1, 0);
    // R3 R4 R5 R6
    cnt_en = 1;
    pulse(0, 1, 0, 0, 0);                   // R5 at zero
    pulse(1, 0, 0, 0, 0); pulse(1, 0, 0, 0, 0); pulse(1, 1, 0, 0, 0);
    pulse(0, 1, 0, 0, 0); pulse(0, 1, 0, 0, 0); pulse(0, 1, 0, 0, 0);
    // R7: run to wrap, then write at zero with flag set
    repeat (CMAX + 1) pulse(1, 0, 0, 0, 0);
    pulse(0, 1, 0, 0, 0);
    // R8 clear after wrap; clear against frame
    pulse(0, 0, 0, 0, 1); pulse(1, 0, 0, 0, 0); pulse(1, 1, 0, 0, 1);
    // R10: single mode ignores strobes
    pulse(1, 0, 0, 0, 0); cur_desc = 3'd5; pulse(0, 0, 1, 0, 0);
    chain_mode = 0;
    pulse(1, 1, 1, 1, 0); pulse(0, 1, 0, 1, 0); pulse(0, 0, 0, 0, 1);
    chain_mode = 1;
    // R11 enable toggles
    pulse(1, 0, 1, 0, 0); eof_ie = 0; idle(2); bof_ie = 0; idle(2); eof_ie = 1; bof_ie = 1; idle(2);
    // Random traffic
    for (int i = 0; i < 6000; i++) begin
      chain_mode = ($urandom % 10) != 0;
      if ($urandom % 50 == 0) cnt_en = ~cnt_en;
      frame_done = ($urandom % 3) == 0;
      eof_w1c    = ($urandom % 3) == 0;
      xfer_req   = ($urandom % 2) == 0;
      bof_w1c    = ($urandom % 3) == 0;
      cnt_clr    = ($urandom % 40) == 0;
      eof_ie     = ($urandom % 8) != 0;
      bof_ie     = ($urandom % 8) != 0;
      cur_desc   = AW'($urandom);
      err_desc   = AW'($urandom);
      @(negedge clk);
    end
    idle(3);
    finish_run();
  end
endmodule